// File: doc/BRIEF.md
# Multichannel Serial-to-Parallel Deserializer

This block takes a group of single-bit serial lanes, all sampled on one fast bit clock, and turns each lane into a parallel word of N bits, where N (the deserialization factor) is a parameter between 4 and 10. A modulo-N counter inside the block marks word boundaries, so the whole block runs on the bit clock alone. It does not need a second, slower frame clock. Each lane's bits are collected in a shift register. Once per frame the finished word moves into a holding register. Every lane's word then appears side by side on one wide output bus.

A parameter adds an optional output register stage, which is on by default. The block also drives two outputs for downstream logic. One is a one-cycle frame enable that marks each new word. The other is a lock flag that says when the output data can be trusted. A clock-source enable input holds the whole block in reset while the source is off.

Top module: `lane_deser`

## Requirements
- R1: The factor N may be any integer from 4 to 10; `parOut` is N*LANES bits wide and `serIn` is LANES bits wide.
- R2: Lane k's word occupies `parOut[k*N+N-1 : k*N]`, with lane 0 in the lowest slice.
- R3: Within a lane's slice, the first bit received for a word is at the most significant position and the last bit received is at bit 0.
- R4: After reset, bits are taken on every rising edge, and each group of N consecutive samples forms one word. `frameEn` pulses high for exactly one cycle every N cycles.
- R5: Count the rising edges since reset was released, starting from 1. Word j (j = 0, 1, ...) uses the bits sampled on edges j*N+1 to (j+1)*N. It appears on `parOut` after edge (j+1)*N+1 when REG_OUT=1, or after edge (j+1)*N when REG_OUT=0.
- R6: Between two frame pulses, `parOut` holds its value.
- R7: While `rst` is high, the shift registers, the counter, `parOut`, `frameEn` and `locked` are cleared on each rising edge.
- R8: `locked` goes high in the same cycle as the first `frameEn` after reset. It then stays high until reset or until `pllEn` goes low.
- R9: With `pllEn` low, the block behaves as if it were in reset: `locked`, `frameEn` and `parOut` read 0 after the next edge, even if `rst` is low.
- R10: `frameEn` is high in exactly the cycles in which `parOut` first shows a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| pllEn | input | 1 | Clock-source enable; low holds the block in reset |
| serIn | input | LANES | One serial bit per lane |
| parOut | output | N*LANES | Packed parallel words, lane 0 lowest |
| frameEn | output | 1 | One-cycle pulse marking a new word on parOut |
| locked | output | 1 | High once the first word has been output, while the source stays enabled |

## Verification
The assertions assume that `rst` and `pllEn` change only between clock edges. They also assume that `pllEn`, once raised, stays high for at least one edge before the lock history is judged. The stimulus changes every input on the falling edge. It keeps `rst` and `pllEn` at fixed levels for whole cycles, dropping them only in directed phases that last several cycles. Serial data is random apart from a few directed words that check lane placement and bit order. The design is checked with two factors, 8 and 5, one built with the output register and one without.

// File: rtl/lane_deser_pkg.sv
package lane_deser_pkg;
  // Strobes from the frame controller to the lane datapath
  typedef struct packed {
    logic clear;    // synchronous clear (reset or source disabled)
    logic shift;    // take one serial bit this cycle
    logic capture;  // last bit of the word: move it into the holding register
  } deserCtl_t;
endpackage

// File: rtl/lane_deser_ctrl.sv
module lane_deser_ctrl
  import lane_deser_pkg::*;
#(
  parameter int N = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pllEn,
  input  logic      frameEn,
  output deserCtl_t ctl,
  output logic      locked
);
  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] bitCnt;
  logic          lockQ;
  logic          clearNow;

  assign clearNow = rst | ~pllEn;

  always_ff @(posedge clk) begin
    if (clearNow)            bitCnt <= '0;
    else if (bitCnt == LAST) bitCnt <= '0;
    else                     bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    ctl.clear   = clearNow;
    ctl.shift   = ~clearNow;
    ctl.capture = ~clearNow && (bitCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (clearNow) lockQ <= 1'b0;
    else          lockQ <= lockQ | frameEn;
  end

  assign locked = lockQ | frameEn;

  // R4: the bit counter never leaves 0..N-1
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= LAST);

  // R4: capture strobes are isolated single cycles
  p_strobe_gap_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.capture |=> !ctl.capture);

  // R9: a disabled source forces the unlocked, cleared state
  p_pll_off_r9: assert property (@(posedge clk) disable iff (rst)
    !pllEn |=> (!locked && bitCnt == '0));

  // R8: lock is sticky while the source stays enabled
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst || !pllEn)
    locked |=> locked);

  // R8: lock only rises together with a frame pulse
  p_lock_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> frameEn);
endmodule

// File: rtl/lane_deser_dp.sv
module lane_deser_dp
  import lane_deser_pkg::*;
#(
  parameter int N       = 8,
  parameter int LANES   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  deserCtl_t          ctl,
  input  logic [LANES-1:0]   serIn,
  output logic [N*LANES-1:0] parOut,
  output logic               frameEn
);
  localparam int W = N * LANES;

  logic [W-1:0] holdQ;
  logic         capQ;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [N-1:0] shReg;
    logic [N-1:0] nextWord;

    // Earliest bit migrates to the MSB as later bits arrive (R3)
    assign nextWord = {shReg[N-2:0], serIn[k]};

    always_ff @(posedge clk) begin
      if (ctl.clear)      shReg <= '0;
      else if (ctl.shift) shReg <= nextWord;
    end

    // Lane k owns slice [k*N +: N] (R2)
    always_ff @(posedge clk) begin
      if (ctl.clear)        holdQ[k*N +: N] <= '0;
      else if (ctl.capture) holdQ[k*N +: N] <= nextWord;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.clear) capQ <= 1'b0;
    else           capQ <= ctl.capture;
  end

  if (REG_OUT) begin : g_outreg
    logic [W-1:0] outQ;
    logic         frmQ;
    always_ff @(posedge clk) begin
      if (ctl.clear) begin
        outQ <= '0;
        frmQ <= 1'b0;
      end else begin
        if (capQ) outQ <= holdQ;
        frmQ <= capQ;
      end
    end
    assign parOut  = outQ;
    assign frameEn = frmQ;
  end else begin : g_direct
    assign parOut  = holdQ;
    assign frameEn = capQ;
  end

  // R6: parallel output only moves with a frame pulse
  p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
    (!frameEn && $past(!ctl.clear)) |-> $stable(parOut));

  // R10: a frame pulse follows a capture by the output latency
  p_frame_after_cap_r10: assert property (@(posedge clk) disable iff (rst || ctl.clear)
    frameEn |-> $past(REG_OUT ? capQ : ctl.capture));
endmodule

// File: rtl/lane_deser.sv
module lane_deser
  import lane_deser_pkg::*;
#(
  parameter int N       = 8,
  parameter int LANES   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pllEn,
  input  logic [LANES-1:0]   serIn,
  output logic [N*LANES-1:0] parOut,
  output logic               frameEn,
  output logic               locked
);
  deserCtl_t ctl;

  lane_deser_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .pllEn   (pllEn),
    .frameEn (frameEn),
    .ctl     (ctl),
    .locked  (locked)
  );

  lane_deser_dp #(.N(N), .LANES(LANES), .REG_OUT(REG_OUT)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .serIn   (serIn),
    .parOut  (parOut),
    .frameEn (frameEn)
  );
endmodule

// File: tb/lane_deser_tb.sv
`timescale 1ns/1ps
module lane_deser_tb;
  localparam int NA = 8;
  localparam int LA = 4;
  localparam int NB = 5;
  localparam int LB = 2;
  localparam int WA = NA * LA;
  localparam int WB = NB * LB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pllEn = 1'b1;
  logic [LA-1:0] serA = '0;
  logic [LB-1:0] serB = '0;
  logic [WA-1:0] outA;
  logic [WB-1:0] outB;
  logic feA, feB, lkA, lkB;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  logic [WA-1:0] histA [256];
  logic [WB-1:0] histB [256];

  always #5 clk = ~clk;

  // R1: factor 8 with output register, factor 5 without
  lane_deser #(.N(NA), .LANES(LA), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .pllEn(pllEn), .serIn(serA),
    .parOut(outA), .frameEn(feA), .locked(lkA));

  lane_deser #(.N(NB), .LANES(LB), .REG_OUT(1'b0)) u_dutB (
    .clk(clk), .rst(rst), .pllEn(pllEn), .serIn(serB),
    .parOut(outB), .frameEn(feB), .locked(lkB));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected outputs after c edges since release, with output latency lat (R5)
  task automatic checkA(input int c);
    int d;
    logic [WA-1:0] e;
    bit fe, lk;
    d = c - 1;
    if (d >= NA) begin
      e = histA[(d / NA - 1) % 256]; fe = (d % NA == 0); lk = 1'b1;
    end else begin
      e = '0; fe = 1'b0; lk = 1'b0;
    end
    chk(outA === e, "R2/R3/R5 A parOut", 64'(outA), 64'(e));
    chk(feA === fe, "R4 R10 A frameEn", 64'(feA), 64'(fe));
    chk(lkA === lk, "R8 A locked", 64'(lkA), 64'(lk));
  endtask

  task automatic checkB(input int c);
    logic [WB-1:0] e;
    bit fe, lk;
    if (c >= NB) begin
      e = histB[(c / NB - 1) % 256]; fe = (c % NB == 0); lk = 1'b1;
    end else begin
      e = '0; fe = 1'b0; lk = 1'b0;
    end
    chk(outB === e, "R2/R3/R5 B parOut", 64'(outB), 64'(e));
    chk(feB === fe, "R4 R10 B frameEn", 64'(feB), 64'(fe));
    chk(lkB === lk, "R8 B locked", 64'(lkB), 64'(lk));
  endtask

  function automatic logic [WA-1:0] dirA(input int j);
    case (j)
      0: return 32'h00FF_0180;  // lane0 = 0x80: only first bit set (R3)
      1: return 32'hAA55_0F3C;
      2: return '1;
      default: return '0;
    endcase
  endfunction

  function automatic logic [WB-1:0] dirB(input int j);
    case (j)
      0: return 10'b10000_00001;  // lane1 first bit only, lane0 last bit only
      1: return 10'b01010_10101;
      2: return '1;
      default: return '0;
    endcase
  endfunction

  // Caller is at a falling edge; stream runs from a fresh frame start
  task automatic runStream(input int cycles, input bit directed);
    for (int c = 0; c < cycles; c++) begin
      checkA(c);
      checkB(c);
      if (c % NA == 0)
        histA[(c / NA) % 256] = (directed && c / NA < 4) ? dirA(c / NA) : WA'($urandom);
      if (c % NB == 0)
        histB[(c / NB) % 256] = (directed && c / NB < 4) ? dirB(c / NB) : WB'($urandom);
      for (int k = 0; k < LA; k++)
        serA[k] = histA[(c / NA) % 256][k*NA + NA - 1 - (c % NA)];
      for (int k = 0; k < LB; k++)
        serB[k] = histB[(c / NB) % 256][k*NB + NB - 1 - (c % NB)];
      rst = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic checkCleared(input string tag);
    chk(outA === '0 && outB === '0, {tag, " parOut cleared"}, 64'({outB, outA}), 64'd0);
    chk(!feA && !feB, {tag, " frameEn low"}, 64'({feB, feA}), 64'd0);
    chk(!lkA && !lkB, {tag, " locked low"}, 64'({lkB, lkA}), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checkCleared("R7 reset");
    runStream(NA * 40, 1'b1);

    // Mid-stream reset (R7)
    rst = 1'b1;
    @(negedge clk);
    checkCleared("R7 midreset");
    @(negedge clk);
    checkCleared("R7 midreset hold");
    runStream(NA * 30 + 3, 1'b0);

    // Source disabled with rst low (R9)
    pllEn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      serA = LA'($urandom);
      serB = LB'($urandom);
      @(negedge clk);
      checkCleared("R9 pll off");
    end
    pllEn = 1'b1;
    runStream(NA * 40, 1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule